// File: doc/BRIEF.md
# Replay FIFO with Mark and Retransmit

A single-clock first-in first-out buffer, 9 bits wide by default, that can replay data. Alongside the usual write and read positions it keeps a third position, the mark. Pulsing `mark` saves the current read position. Pulsing `retransmit` moves the read position back to the saved mark. Everything from the marked word onward can then be read again, and the writer never has to supply it a second time. The typical use is a packet link: mark the first word of a packet, send the packet, and replay it if the receiver reports an error.

Writes arrive on a valid/ready stream. A word is taken on any cycle where `in_valid` and `in_ready` are both high. `in_ready` drops only when the buffer holds DEPTH words, so the writer may hold `in_valid` high and wait. Reads are strobes: `rd_en` asks for one word. One cycle after an accepted read, `out_valid` is high and `out_data` carries the word. The read side has no back-pressure, so the consumer must take the word in that cycle.

`occupancy` is an (AW+1)-bit count for a separate flag block. A sticky `mark_overrun` bit warns that writes have lapped the marked word, so a replay would return overwritten data. DEPTH must be a power of two.

Top module: `mark_fifo`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `occupancy` is 0, `in_ready` is 1, `out_valid` is 0 and `mark_overrun` is 0. Reset also clears the read, write and mark positions to zero.
- R2: A write is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is 0 exactly when `occupancy` equals DEPTH. A write offered while full is ignored, and `occupancy` stays at DEPTH.
- R3: A read is accepted when `rd_en` is high, `occupancy` is nonzero and `retransmit` is low. A read request while `occupancy` is 0 is ignored: `out_valid` stays 0 and `occupancy` stays 0.
- R4: Accepted reads return words in the order in which they were written. The word appears on `out_data` in the cycle after the read is accepted.
- R5: `occupancy` equals the write position minus the read position. It rises by one for each accepted write, falls by one for each accepted read, and is unchanged when a write and a read are accepted together.
- R6: A `mark` pulse saves the read position. A `retransmit` pulse loads the read position from the mark. Later reads then start at the marked word, and `occupancy` grows by the number of words replayed.
- R7: Retransmit may be repeated any number of times from the same mark, and every repeat replays from the same word.
- R8: When `mark` and `retransmit` are high in the same cycle, the retransmit is performed and the saved mark keeps its old value.
- R9: When `rd_en` and `retransmit` are high in the same cycle, the read is discarded. `out_valid` is 0 in the next cycle and the read position becomes the mark.
- R10: `mark_overrun` becomes 1 after an accepted write lands on the marked slot exactly one full lap (DEPTH words) ahead of the mark. This applies only once a mark has been taken since reset. The bit then stays 1 until reset.
- R11: `out_valid` is 1 for exactly the cycle after each accepted read and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| in_valid | input | 1 | Write word offered |
| in_data | input | DATA_W | Write word |
| in_ready | output | 1 | Buffer can take a word (not full) |
| rd_en | input | 1 | Read strobe, one word per cycle |
| out_valid | output | 1 | `out_data` holds a word read on the previous edge |
| out_data | output | DATA_W | Read word |
| mark | input | 1 | Save the current read position |
| retransmit | input | 1 | Reload the read position from the mark |
| occupancy | output | AW+1 | Words held, write position minus read position |
| mark_overrun | output | 1 | Sticky: writes have lapped the marked slot |

## Verification
The bench first marks a word in the middle of a stream and retransmits from it twice. A design that replayed from the wrong word, or that failed to grow `occupancy` by the replayed count, returns the wrong data or count. It then drives mark and retransmit together, and read and retransmit together. A wrong priority would move the mark, which the next retransmit exposes, or would emit a spurious `out_valid`. Finally it fills the buffer until a write laps a held mark, and repeats the lap with no mark taken since reset. A design with an off-by-one lap test, a bit that is not sticky, or no check for a taken mark flags the wrong case. It also checks that extra writes at full and reads at empty leave `occupancy` and `out_valid` untouched.

// File: rtl/mark_fifo_pkg.sv
package mark_fifo_pkg;
  localparam int unsigned MF_DATA_W_DEF = 9;
  localparam int unsigned MF_DEPTH_DEF  = 2048;

  // Position that sits exactly one lap ahead of p (top wrap bit flipped).
  function automatic logic [31:0] mf_lap_bit(input int unsigned aw);
    return 32'd1 << aw;
  endfunction
endpackage

// File: rtl/mf_ram.sv
module mf_ram #(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned DEPTH  = 2048,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/mf_ptr_ctrl.sv
module mf_ptr_ctrl #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          rd_en,
  input  logic          mark,
  input  logic          retransmit,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [PW-1:0] wr_pos,
  output logic [PW-1:0] mark_pos,
  output logic [PW-1:0] count,
  output logic          in_ready,
  output logic          out_valid,
  output logic          mark_take
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  logic [PW-1:0] rd_pos;
  logic          is_full, is_empty;

  assign count     = wr_pos - rd_pos;
  assign is_full   = (count == FULL_CNT);
  assign is_empty  = (count == '0);
  assign in_ready  = !is_full;
  assign wr_fire   = in_valid && !is_full;
  assign rd_fire   = rd_en && !is_empty && !retransmit;
  assign mark_take = mark && !retransmit;
  assign wr_addr   = wr_pos[AW-1:0];
  assign rd_addr   = rd_pos[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pos    <= '0;
      rd_pos    <= '0;
      mark_pos  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= rd_fire;
      if (wr_fire)         wr_pos   <= wr_pos + 1'b1;
      if (retransmit)      rd_pos   <= mark_pos;
      else if (rd_fire)    rd_pos   <= rd_pos + 1'b1;
      if (mark_take)       mark_pos <= rd_pos;
    end
  end

  // R2: never holds more than DEPTH words
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  // R2: an offered write at full leaves the count alone when nothing else moves
  a_r2_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && in_valid && !rd_en && !retransmit) |=> (count == FULL_CNT));
  // R3: a read at empty yields no data
  a_r3_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && rd_en) |=> !out_valid);
  // R6: retransmit reloads the read position from the mark
  a_r6_rt_reload: assert property (@(posedge clk) disable iff (!rst_n)
    retransmit |=> (rd_pos == $past(mark_pos)));
  // R8: retransmit beats mark, the mark keeps its value
  a_r8_mark_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (mark && retransmit) |=> $stable(mark_pos));
  // R9: a read beside a retransmit is dropped
  a_r9_rt_drops_read: assert property (@(posedge clk) disable iff (!rst_n)
    retransmit |=> !out_valid);
endmodule

// File: rtl/mf_mark_guard.sv
module mf_mark_guard #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mark_take,
  input  logic          wr_fire,
  input  logic [PW-1:0] wr_pos,
  input  logic [PW-1:0] mark_pos,
  output logic          overrun
);
  import mark_fifo_pkg::*;

  logic          held;
  logic [PW-1:0] lap_pos;
  logic          hit;

  assign lap_pos = mark_pos ^ mf_lap_bit(AW)[PW-1:0];
  assign hit     = held && wr_fire && (wr_pos == lap_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (mark_take) held <= 1'b1;
      if (hit)       overrun <= 1'b1;
    end
  end

  // R10: sticky until reset
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R10: never raised before a mark has been taken
  a_r10_needs_mark: assert property (@(posedge clk) disable iff (!rst_n)
    !held |=> !overrun);
endmodule

// File: rtl/mark_fifo.sv
module mark_fifo #(
  parameter int unsigned DATA_W = mark_fifo_pkg::MF_DATA_W_DEF,
  parameter int unsigned DEPTH  = mark_fifo_pkg::MF_DEPTH_DEF,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              rd_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              mark,
  input  logic              retransmit,
  output logic [AW:0]       occupancy,
  output logic              mark_overrun
);
  logic          wr_fire, rd_fire, mark_take;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [AW:0]   wr_pos, mark_pos;

  mf_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .rd_en      (rd_en),
    .mark       (mark),
    .retransmit (retransmit),
    .wr_fire    (wr_fire),
    .rd_fire    (rd_fire),
    .wr_addr    (wr_addr),
    .rd_addr    (rd_addr),
    .wr_pos     (wr_pos),
    .mark_pos   (mark_pos),
    .count      (occupancy),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .mark_take  (mark_take)
  );

  mf_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk     (clk),
    .wr_en   (wr_fire),
    .wr_addr (wr_addr),
    .wr_data (in_data),
    .rd_en   (rd_fire),
    .rd_addr (rd_addr),
    .rd_data (out_data)
  );

  mf_mark_guard #(.DEPTH(DEPTH)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .mark_take (mark_take),
    .wr_fire   (wr_fire),
    .wr_pos    (wr_pos),
    .mark_pos  (mark_pos),
    .overrun   (mark_overrun)
  );

  // R11: out_valid only follows a cycle that could read
  a_r11_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(rd_en && !retransmit && occupancy != '0));
  // R1: clean state right after reset release
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (occupancy == '0 && !out_valid && !mark_overrun));
endmodule

// File: tb/tb_mark_fifo.sv
module tb_mark_fifo;
  localparam int unsigned DW = 9;
  localparam int unsigned DP = 8;
  localparam int unsigned AW = $clog2(DP);
  localparam int NVEC = 19;

  // {wv, wd[8:0], re, mk, rt, exp_valid, exp_data[8:0], exp_occ[3:0]}
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b1, 9'h011, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000, 4'd1},  // R5
    {1'b1, 9'h022, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000, 4'd2},
    {1'b1, 9'h033, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000, 4'd3},
    {1'b0, 9'h000, 1'b1, 1'b0, 1'b0, 1'b1, 9'h011, 4'd2},  // R4
    {1'b1, 9'h044, 1'b0, 1'b1, 1'b0, 1'b0, 9'h000, 4'd3},  // R6 mark
    {1'b0, 9'h000, 1'b1, 1'b0, 1'b0, 1'b1, 9'h022, 4'd2},
    {1'b1, 9'h055, 1'b1, 1'b0, 1'b0, 1'b1, 9'h033, 4'd2},  // R5 rd+wr
    {1'b0, 9'h000, 1'b0, 1'b0, 1'b1, 1'b0, 9'h000, 4'd4},  // R6 retransmit
    {1'b0, 9'h000, 1'b1, 1'b0, 1'b0, 1'b1, 9'h022, 4'd3},  // R6 replay
    {1'b0, 9'h000, 1'b1, 1'b0, 1'b1, 1'b0, 9'h000, 4'd4},  // R9
    {1'b0, 9'h000, 1'b1, 1'b0, 1'b0, 1'b1, 9'h022, 4'd3},  // R7
    {1'b0, 9'h000, 1'b0, 1'b1, 1'b1, 1'b0, 9'h000, 4'd4},  // R8
    {1'b0, 9'h000, 1'b1, 1'b0, 1'b0, 1'b1, 9'h022, 4'd3},
    {1'b0, 9'h000, 1'b0, 1'b0, 1'b1, 1'b0, 9'h000, 4'd4},  // R8 mark kept
    {1'b0, 9'h000, 1'b1, 1'b0, 1'b0, 1'b1, 9'h022, 4'd3},
    {1'b0, 9'h000, 1'b1, 1'b0, 1'b0, 1'b1, 9'h033, 4'd2},
    {1'b0, 9'h000, 1'b1, 1'b0, 1'b0, 1'b1, 9'h044, 4'd1},
    {1'b0, 9'h000, 1'b1, 1'b0, 1'b0, 1'b1, 9'h055, 4'd0},
    {1'b0, 9'h000, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000, 4'd0}   // R3 empty read
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready;
  logic          rd_en = 1'b0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          mark = 1'b0;
  logic          retransmit = 1'b0;
  logic [AW:0]   occupancy;
  logic          mark_overrun;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mark_fifo #(.DATA_W(DW), .DEPTH(DP)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rd_en(rd_en), .out_valid(out_valid),
    .out_data(out_data), .mark(mark), .retransmit(retransmit),
    .occupancy(occupancy), .mark_overrun(mark_overrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic cyc(input logic wv, input logic [DW-1:0] wd, input logic re,
                     input logic mk, input logic rt);
    in_valid = wv; in_data = wd; rd_en = re; mark = mk; retransmit = rt;
    @(negedge clk);
    in_valid = 1'b0; rd_en = 1'b0; mark = 1'b0; retransmit = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 occupancy in reset", int'(occupancy), 0);
    chk("R1 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 occupancy", int'(occupancy), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 mark_overrun", int'(mark_overrun), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    for (int i = 0; i < NVEC; i++) begin
      logic [26:0] v;
      v = VEC[i];
      cyc(v[26], v[25:17], v[16], v[15], v[14]);
      chk($sformatf("R4/R6 vec%0d out_valid", i), int'(out_valid), int'(v[13]));
      if (v[13]) chk($sformatf("R4/R7 vec%0d out_data", i), int'(out_data), int'(v[12:4]));
      chk($sformatf("R5 vec%0d occupancy", i), int'(occupancy), int'(v[3:0]));
    end

    // State now: read = write = 5, mark = 1 and held. Writes at 5..8 stay in lap.
    for (int i = 0; i < 4; i++) cyc(1'b1, DW'(9'h100 + i), 1'b0, 1'b0, 1'b0);
    chk("R10 no overrun before lap", int'(mark_overrun), 0);
    cyc(1'b1, 9'h104, 1'b0, 1'b0, 1'b0);   // lands on slot 1 at position 9
    chk("R10 overrun on lap", int'(mark_overrun), 1);
    for (int i = 5; i < 8; i++) cyc(1'b1, DW'(9'h100 + i), 1'b0, 1'b0, 1'b0);
    chk("R2 occupancy full", int'(occupancy), DP);
    chk("R2 in_ready low at full", int'(in_ready), 0);
    cyc(1'b1, 9'h1AA, 1'b0, 1'b0, 1'b0);
    chk("R2 write at full ignored", int'(occupancy), DP);
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
      chk("R4 full drain order", int'(out_data), 9'h100 + i);
      chk("R11 out_valid per read", int'(out_valid), 1);
    end
    chk("R10 overrun sticky", int'(mark_overrun), 1);
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b0);
    chk("R11 out_valid drops", int'(out_valid), 0);
    cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
    chk("R3 empty read no valid", int'(out_valid), 0);
    chk("R3 empty read occupancy", int'(occupancy), 0);

    do_reset();

    // Lap without any mark taken since reset: no overrun.
    for (int i = 0; i < 8; i++) cyc(1'b1, DW'(i), 1'b0, 1'b0, 1'b0);
    cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
    chk("R4 first word after reset", int'(out_data), 0);
    cyc(1'b1, 9'h0F0, 1'b0, 1'b0, 1'b0);
    chk("R10 no mark no overrun", int'(mark_overrun), 0);
    chk("R2 refill to full", int'(occupancy), DP);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule